// File: doc/BRIEF.md
# Interleaved Luma Bank Read Sequencer

This block sits on a slow host bus beside a fast 8-bit SRAM that is divided into sixteen equal banks. The host's video fetch engine samples read data only when its bus clock `phi2` falls, which leaves most of each bus cycle idle. The sequencer runs on a clock eight times the bus rate and fills that idle time with extra SRAM reads. When enhancement is enabled, every host read that hits the cartridge window becomes three reads in a fixed order. The first two fetch a 16-bit luma word for a downstream pixel serializer. The last fetches the byte that the host expects, and the block drives that byte back onto the bus before `phi2` falls.

A small control register sets the base bank and the enhancement mode. The host writes it by selecting the control page with a write strobe. With the mode at zero, the window behaves as plain banked memory: one access per bus cycle, reads and writes alike, in the bank the register selects. The block drives only the bank-select address lines and the SRAM strobes. The offset inside a bank comes straight from the host address bus.

Top module: `luma_bank_sequencer`

## Requirements
- R1: While `rst` is high and on the clock after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `host_doe` and `luma_valid` are 0, and `luma_word`, `luma_mode` and the base bank are 0.
- R2: A bus cycle with `ctl_sel_n`=0 and `bus_rw`=0 loads the control register from `ctl_data`, bank in bits 3:0 and mode in bits 5:4. `luma_mode` shows the new mode by the last phase of that cycle. The same select with `bus_rw`=1 leaves the register unchanged.
- R3: A bus cycle starts at the first clock edge that sees `phi2` low after it was high. That edge and the following edges number phases 0 to 7. The SRAM outputs for phase k are valid in the clock period that follows edge k.
- R4: A window read (`win_sel_n`=0, `bus_rw`=1) with a nonzero mode keeps `sram_ce_n` and `sram_oe_n` low in all 8 phases. It drives bank base+2 in phases 0-2, base+1 in phases 3-5 and base in phases 6-7, with the sum taken modulo 16.
- R5: In such a cycle `luma_word` becomes {byte of base+2, byte of base+1}, the first byte read being the high byte. `luma_valid` is high during phase 6 only, for one clock.
- R6: In any window read, `host_doe` is 1 with `host_dout` equal to the base-bank byte during phase 7. It stays 1 until the next `phi2` fall and is 0 in phases 0-6.
- R7: A window read with mode 0 accesses only the base bank in all phases, gives no `luma_valid` pulse and leaves `luma_word` unchanged.
- R8: A window write (`win_sel_n`=0, `bus_rw`=0) in any mode accesses only the base bank with `sram_oe_n` high, and holds `sram_we_n` low in phases 4, 5 and 6 only.
- R9: A cycle with neither select low, such as a refresh cycle, keeps `sram_ce_n` high and gives no `host_doe` and no `luma_valid`.
- R10: `sram_we_n` is never low unless `sram_ce_n` is low, and `sram_oe_n` and `sram_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, 8x the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Host bus clock, aligned to `clk` |
| bus_rw | input | 1 | 1 = host read, 0 = host write |
| win_sel_n | input | 1 | Active-low cartridge window select |
| ctl_sel_n | input | 1 | Active-low control page select |
| ctl_data | input | 6 | Data bus lines that carry the control fields |
| sram_rdata | input | 8 | Read data from the SRAM |
| host_dout | output | 8 | Byte returned to the host |
| host_doe | output | 1 | Drive enable for `host_dout` |
| sram_bank | output | 4 | SRAM bank-select address lines |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| luma_word | output | 16 | Latched luma word for the serializer |
| luma_valid | output | 1 | One-clock strobe for a new `luma_word` |
| luma_mode | output | 2 | Current enhancement mode |

## Verification
A wrong phase count shows up within the same bus cycle. The bank lines step at the wrong phase, `luma_valid` moves away from phase 6, or `host_doe` rises early, so the per-phase bank sweep catches it in the first enhanced read. A wrong bank offset or byte order corrupts `luma_word` or `host_dout` at phase 7 of that cycle. Sweeping every base bank also exposes wrap-around faults at banks 14 and 15. A faulty control register shows up one cycle later, at the next window access, as a wrong bank on `sram_bank` or a wrong `luma_mode`.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_LUMA_RD,
    ACC_PLAIN_RD,
    ACC_SRAM_WR,
    ACC_CTL_WR
  } acc_kind_t;

  // Read slot that a phase belongs to when a bus cycle of `phases`
  // clocks is shared by `reads` accesses.
  function automatic int slot_of(input int p, input int phases, input int reads);
    return (p * reads) / phases;
  endfunction

  // Last phase that belongs to slot s.
  function automatic int slot_last_phase(input int s, input int phases, input int reads);
    return ((s + 1) * phases + reads - 1) / reads - 1;
  endfunction

endpackage

// File: rtl/lbs_phase_gen.sv
module lbs_phase_gen #(
  parameter int PHASES = 8,
  parameter int PH_W   = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            phi2,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] nph,
  output logic            fall
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic phi2_q;

  assign fall = phi2_q & ~phi2;

  always_comb begin
    if (fall)
      nph = '0;
    else if (ph == PH_LAST)
      nph = ph;
    else
      nph = ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q <= 1'b0;
      ph     <= PH_LAST;
    end else begin
      phi2_q <= phi2;
      ph     <= nph;
    end
  end
endmodule

// File: rtl/lbs_ctrl_reg.sv
module lbs_ctrl_reg #(
  parameter int BANK_W = 4,
  parameter int MODE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [BANK_W+MODE_W-1:0] wdata,
  output logic [BANK_W-1:0]        bank,
  output logic [MODE_W-1:0]        mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '0;
      mode <= '0;
    end else if (wr_en) begin
      bank <= wdata[BANK_W-1:0];
      mode <= wdata[BANK_W+MODE_W-1:BANK_W];
    end
  end
endmodule

// File: rtl/lbs_access_sched.sv
module lbs_access_sched
  import lbs_pkg::*;
#(
  parameter int PHASES     = 8,
  parameter int PH_W       = $clog2(PHASES),
  parameter int BANK_W     = 4,
  parameter int LUMA_READS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   nph,
  input  acc_kind_t         kind,
  input  logic [BANK_W-1:0] base,
  output logic [BANK_W-1:0] sram_bank,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  localparam int READS    = LUMA_READS + 1;
  localparam int WE_FIRST = PHASES / 2;
  localparam int WE_LAST  = PHASES - 2;

  logic [BANK_W-1:0] luma_bank;
  logic              we_window;

  always_comb begin
    int off;
    off       = LUMA_READS - slot_of(int'(nph), PHASES, READS);
    luma_bank = base + BANK_W'(off);
    we_window = (int'(nph) >= WE_FIRST) && (int'(nph) <= WE_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_bank <= '0;
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
    end else begin
      sram_bank <= base;
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      case (kind)
        ACC_LUMA_RD: begin
          sram_bank <= luma_bank;
          sram_ce_n <= 1'b0;
          sram_oe_n <= 1'b0;
        end
        ACC_PLAIN_RD: begin
          sram_ce_n <= 1'b0;
          sram_oe_n <= 1'b0;
        end
        ACC_SRAM_WR: begin
          sram_ce_n <= 1'b0;
          sram_we_n <= ~we_window;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lbs_capture.sv
module lbs_capture
  import lbs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PHASES     = 8,
  parameter int PH_W       = $clog2(PHASES),
  parameter int LUMA_READS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [PH_W-1:0]              ph,
  input  logic                         fall,
  input  acc_kind_t                    kind,
  input  logic [DATA_W-1:0]            rdata,
  output logic [DATA_W-1:0]            host_dout,
  output logic                         host_doe,
  output logic [DATA_W*LUMA_READS-1:0] luma_word,
  output logic                         luma_valid
);
  localparam int READS    = LUMA_READS + 1;
  localparam int LAST_CAP = slot_last_phase(LUMA_READS - 1, PHASES, READS);
  localparam int HOST_CAP = PHASES - 2;

  logic                         step;
  logic                         luma_rd;
  logic [DATA_W*LUMA_READS-1:0] assembled;

  assign step    = ~fall;
  assign luma_rd = (kind == ACC_LUMA_RD);

  // Earlier luma bytes are staged; the last one joins straight from the SRAM.
  for (genvar g = 0; g < LUMA_READS - 1; g++) begin : g_stage
    localparam int CAP = slot_last_phase(g, PHASES, READS);
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk) begin
      if (rst)
        byte_q <= '0;
      else if (step && luma_rd && ph == PH_W'(CAP))
        byte_q <= rdata;
    end

    assign assembled[(LUMA_READS-1-g)*DATA_W +: DATA_W] = byte_q;
  end
  assign assembled[DATA_W-1:0] = rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      luma_word  <= '0;
      luma_valid <= 1'b0;
    end else begin
      luma_valid <= 1'b0;
      if (step && luma_rd && ph == PH_W'(LAST_CAP)) begin
        luma_word  <= assembled;
        luma_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_dout <= '0;
      host_doe  <= 1'b0;
    end else if (fall) begin
      host_doe <= 1'b0;
    end else if (ph == PH_W'(HOST_CAP) &&
                 (kind == ACC_LUMA_RD || kind == ACC_PLAIN_RD)) begin
      host_dout <= rdata;
      host_doe  <= 1'b1;
    end
  end
endmodule

// File: rtl/luma_bank_sequencer.sv
module luma_bank_sequencer
  import lbs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 4,
  parameter int MODE_W     = 2,
  parameter int PHASES     = 8,
  parameter int LUMA_READS = 2,
  parameter int PH_W       = $clog2(PHASES),
  parameter int CTRL_W     = BANK_W + MODE_W,
  parameter int LUMA_W     = DATA_W * LUMA_READS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic              bus_rw,
  input  logic              win_sel_n,
  input  logic              ctl_sel_n,
  input  logic [CTRL_W-1:0] ctl_data,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_doe,
  output logic [BANK_W-1:0] sram_bank,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [LUMA_W-1:0] luma_word,
  output logic              luma_valid,
  output logic [MODE_W-1:0] luma_mode
);
  localparam int CTL_CAP = PHASES - 2;

  logic [PH_W-1:0]   ph;
  logic [PH_W-1:0]   nph;
  logic              fall;
  logic [BANK_W-1:0] base;
  logic [MODE_W-1:0] mode;
  logic              ctl_wr;
  acc_kind_t         kind;

  always_comb begin
    kind = ACC_IDLE;
    if (!win_sel_n) begin
      if (!bus_rw)
        kind = ACC_SRAM_WR;
      else if (mode != '0)
        kind = ACC_LUMA_RD;
      else
        kind = ACC_PLAIN_RD;
    end else if (!ctl_sel_n && !bus_rw) begin
      kind = ACC_CTL_WR;
    end
  end

  assign ctl_wr    = (kind == ACC_CTL_WR) && !fall && (ph == PH_W'(CTL_CAP));
  assign luma_mode = mode;

  lbs_phase_gen #(.PHASES(PHASES), .PH_W(PH_W)) u_phase (
    .clk (clk),
    .rst (rst),
    .phi2(phi2),
    .ph  (ph),
    .nph (nph),
    .fall(fall)
  );

  lbs_ctrl_reg #(.BANK_W(BANK_W), .MODE_W(MODE_W)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .wr_en(ctl_wr),
    .wdata(ctl_data),
    .bank (base),
    .mode (mode)
  );

  lbs_access_sched #(
    .PHASES(PHASES), .PH_W(PH_W), .BANK_W(BANK_W), .LUMA_READS(LUMA_READS)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .nph      (nph),
    .kind     (kind),
    .base     (base),
    .sram_bank(sram_bank),
    .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n)
  );

  lbs_capture #(
    .DATA_W(DATA_W), .PHASES(PHASES), .PH_W(PH_W), .LUMA_READS(LUMA_READS)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .fall      (fall),
    .kind      (kind),
    .rdata     (sram_rdata),
    .host_dout (host_dout),
    .host_doe  (host_doe),
    .luma_word (luma_word),
    .luma_valid(luma_valid)
  );
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker (
  input logic clk,
  input logic rst,
  input logic sram_ce_n,
  input logic sram_oe_n,
  input logic sram_we_n,
  input logic host_doe,
  input logic luma_valid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (sram_ce_n && sram_oe_n && sram_we_n && !host_doe && !luma_valid));

  // R10
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n);

  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!sram_oe_n && !sram_we_n));

  // R9
  idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    sram_ce_n |-> (sram_oe_n && sram_we_n));

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    luma_valid |=> !luma_valid);

  // R5
  valid_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    luma_valid |-> (!sram_ce_n && !sram_oe_n));

  // R6
  doe_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    host_doe |-> sram_we_n);

  // R6
  doe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_doe) |-> $past(!sram_oe_n));
endmodule

bind luma_bank_sequencer lbs_checker u_lbs_chk (
  .clk       (clk),
  .rst       (rst),
  .sram_ce_n (sram_ce_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .host_doe  (host_doe),
  .luma_valid(luma_valid)
);

// File: tb/luma_bank_sequencer_test.sv
module luma_bank_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi2 = 1'b1;
  logic        bus_rw = 1'b1;
  logic        win_sel_n = 1'b1;
  logic        ctl_sel_n = 1'b1;
  logic [7:0]  bus_data = 8'h00;
  logic [7:0]  sram_rdata;
  logic [7:0]  host_dout;
  logic        host_doe;
  logic [3:0]  sram_bank;
  logic        sram_ce_n, sram_oe_n, sram_we_n;
  logic [15:0] luma_word;
  logic        luma_valid;
  logic [1:0]  luma_mode;

  int checks = 0;
  int errors = 0;

  logic [7:0]  exp_mem [16];
  logic [7:0]  sram_mem [16];
  logic [3:0]  sh_bank = 4'd0;
  logic [1:0]  sh_mode = 2'd0;
  logic [15:0] sh_luma = 16'h0000;

  always #2 clk = ~clk;

  luma_bank_sequencer uut (
    .clk(clk), .rst(rst), .phi2(phi2), .bus_rw(bus_rw),
    .win_sel_n(win_sel_n), .ctl_sel_n(ctl_sel_n), .ctl_data(bus_data[5:0]),
    .sram_rdata(sram_rdata), .host_dout(host_dout), .host_doe(host_doe),
    .sram_bank(sram_bank), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .luma_word(luma_word), .luma_valid(luma_valid),
    .luma_mode(luma_mode)
  );

  // External SRAM model, one byte per bank.
  assign sram_rdata = (!sram_ce_n && !sram_oe_n) ? sram_mem[sram_bank] : 8'h00;
  always @(posedge clk)
    if (!sram_ce_n && !sram_we_n) sram_mem[sram_bank] <= bus_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One host bus cycle of 8 clocks; entered and left at a falling clk edge.
  task automatic bus(input logic w_n, input logic c_n, input logic rw_v, input logic [7:0] d);
    int kind;
    logic [3:0] b;
    int bank_bad, ce_bad, oe_bad, we_bad, valid_bad, doe_bad;
    logic [3:0] eb;
    bit ce_lo, oe_lo, we_lo, vld, doe;
    b = sh_bank;
    bank_bad = 0; ce_bad = 0; oe_bad = 0; we_bad = 0; valid_bad = 0; doe_bad = 0;
    if (!w_n) kind = rw_v ? ((sh_mode != 2'd0) ? 1 : 2) : 3;
    else if (!c_n && !rw_v) kind = 4;
    else kind = 0;
    phi2 = 1'b0; win_sel_n = w_n; ctl_sel_n = c_n; bus_rw = rw_v; bus_data = d;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ce_lo = (kind >= 1 && kind <= 3);
      oe_lo = (kind == 1 || kind == 2);
      we_lo = (kind == 3) && k >= 4 && k <= 6;
      vld   = (kind == 1) && k == 6;
      doe   = oe_lo && k == 7;
      if (kind == 1) eb = (k <= 2) ? b + 4'd2 : (k <= 5) ? b + 4'd1 : b;
      else eb = b;
      if (sram_ce_n !== !ce_lo) ce_bad++;
      if (sram_oe_n !== !oe_lo) oe_bad++;
      if (sram_we_n !== !we_lo) we_bad++;
      if (luma_valid !== vld) valid_bad++;
      if (host_doe !== doe) doe_bad++;
      if (ce_lo && sram_bank !== eb) bank_bad++;
      if (k == 3) phi2 = 1'b1;
      if (k == 7) begin
        if (kind == 1) begin
          sh_luma = {exp_mem[b + 4'd2], exp_mem[b + 4'd1]};
          chk(luma_word === sh_luma, "R5 luma word", luma_word, sh_luma);
        end
        if (kind == 2)
          chk(luma_word === sh_luma, "R7 luma word kept", luma_word, sh_luma);
        if (oe_lo)
          chk(host_dout === exp_mem[b], "R6 host byte", host_dout, exp_mem[b]);
      end
    end
    case (kind)
      1: begin
        chk(bank_bad == 0, "R4 bank order", bank_bad, 0);
        chk(ce_bad + oe_bad == 0, "R4 strobes", ce_bad + oe_bad, 0);
        chk(valid_bad == 0, "R5 valid in phase 6", valid_bad, 0);
        chk(doe_bad == 0, "R6 drive window", doe_bad, 0);
      end
      2: begin
        chk(bank_bad + ce_bad + oe_bad == 0, "R7 single bank", bank_bad + ce_bad + oe_bad, 0);
        chk(valid_bad == 0, "R7 no valid", valid_bad, 0);
        chk(doe_bad == 0, "R6 drive window", doe_bad, 0);
      end
      3: begin
        chk(we_bad == 0, "R8 write phases", we_bad, 0);
        chk(bank_bad + ce_bad + oe_bad == 0, "R8 write bank", bank_bad + ce_bad + oe_bad, 0);
        exp_mem[b] = d;
      end
      default: begin
        chk(ce_bad + oe_bad + we_bad + valid_bad + doe_bad == 0, "R9 idle bus",
            ce_bad + oe_bad + we_bad + valid_bad + doe_bad, 0);
        if (kind == 4) begin
          sh_bank = d[3:0];
          sh_mode = d[5:4];
        end
        chk(luma_mode === sh_mode, "R2 mode field", luma_mode, sh_mode);
      end
    endcase
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      sram_mem[i] = 8'h00;
      exp_mem[i]  = 8'h00;
    end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes idle",
        {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
    chk(!host_doe && !luma_valid && luma_word == 16'h0 && luma_mode == 2'd0,
        "R1 outputs cleared", {host_doe, luma_valid, luma_mode}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(sram_ce_n && !host_doe, "R1 after release", {sram_ce_n, host_doe}, 2'b10);

    // Fill every bank in mode 0 (R8), checking each write.
    for (int b = 0; b < 16; b++) begin
      bus(1'b1, 1'b0, 1'b0, {4'h0, 4'(b)});
      bus(1'b0, 1'b1, 1'b0, 8'((b * 53 + 17) & 255));
    end

    // Sweep every mode and every base bank with window reads (R3-R7).
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 16; b++) begin
        bus(1'b1, 1'b0, 1'b0, {2'b00, 2'(m), 4'(b)});
        bus(1'b0, 1'b1, 1'b1, 8'h00);
      end
      bus(1'b1, 1'b1, 1'b1, 8'h00);   // refresh-like idle cycle, R9
    end

    // R2: control select with a read does not change the register.
    bus(1'b1, 1'b0, 1'b0, 8'h13);     // mode 1, bank 3
    bus(1'b1, 1'b0, 1'b1, 8'h2C);
    bus(1'b0, 1'b1, 1'b1, 8'h00);     // bank order must still be 5,4,3

    // R8: write in enhanced mode lands in the base bank only.
    bus(1'b1, 1'b0, 1'b0, 8'h29);     // mode 2, bank 9
    bus(1'b0, 1'b1, 1'b0, 8'hA5);
    bus(1'b1, 1'b0, 1'b0, 8'h27);     // mode 2, bank 7
    bus(1'b0, 1'b1, 1'b1, 8'h00);     // luma must be {A5, byte of bank 8}
    bus(1'b1, 1'b0, 1'b0, 8'h09);     // mode 0, bank 9
    bus(1'b0, 1'b1, 1'b1, 8'h00);     // plain read returns A5

    // R4 wrap: base 15 reads 1, 0, 15.
    bus(1'b1, 1'b0, 1'b0, 8'h3F);
    bus(1'b0, 1'b1, 1'b1, 8'h00);
    bus(1'b1, 1'b1, 1'b1, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule